// File: doc/BRIEF.md
# SPI serial clock generator

This block derives the serial clock of an SPI controller from the system clock. A power-of-two prescaler turns the system clock into a stream of ticks. Two 8-bit counts then set how many ticks the clock spends high and how many it spends low, so the duty cycle is adjustable. The clock polarity input picks the idle level. The phase input picks which edge of each bit carries the sample strobe and which carries the shift strobe. Both strobes are single system-clock pulses that a data shifter can use directly.

A sequencer raises the enable input to start the clock and lowers it to stop. A clock that is at its active level always finishes that half period first, so it never produces a short pulse. In timer mode the serial clock stays idle. The two counts are joined into one 16-bit reload value, and an expiry pulse repeats every reload count of prescaled ticks.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is held, and afterwards while `en` is low, `sclk` equals `cpol` and `sample_stb`, `shift_stb` and `timer_expire` are 0.
- R2: One prescaled tick lasts 2^`prescale_exp` system clocks, and every phase length and timer period scales by this factor.
- R3: With the clock running, `sclk` stays high for `hi_len` ticks and low for `lo_len` ticks.
- R4: A value of 0 in `hi_len` or `lo_len` makes that phase one tick long.
- R5: `cpol` = 0 makes the clock idle low. `cpol` = 1 makes it idle high. In both cases `sclk` = `cpol` XOR active-level.
- R6: With `cpha` = 0, `sample_stb` fires on the leading edge (idle to active) and `shift_stb` on the trailing edge. With `cpha` = 1 the two are swapped. The strobes never fire together.
- R7: Each strobe is exactly one system clock wide and is high in the first cycle in which `sclk` shows its new level. Every edge of `sclk` in clock mode carries exactly one strobe.
- R8: When `en` falls while `sclk` is at its active level, the current phase completes and ends with a trailing edge and its strobe. The clock then stays idle with no strobes. If `sclk` is already idle, it stops at once.
- R9: In timer mode with `en` high, `sclk` stays at `cpol` and no strobes fire. `timer_expire` pulses for one cycle every R ticks, where R = {`hi_len`, `lo_len`} (high count in bits 15:8). R = 0 means 65536 ticks.
- R10: After `en` rises from idle, the first leading edge appears once the idle-level phase has lasted its full length. That length is `lo_len` ticks when `cpol` = 0 and `hi_len` ticks when `cpol` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request from the sequencer |
| timer_mode | input | 1 | 1 selects the reload timer instead of the serial clock |
| prescale_exp | input | 4 | Prescaler exponent; one tick is 2^value system clocks |
| hi_len | input | 8 | High-phase length in ticks (0 = one tick); reload bits 15:8 in timer mode |
| lo_len | input | 8 | Low-phase length in ticks (0 = one tick); reload bits 7:0 in timer mode |
| cpol | input | 1 | Clock polarity; the idle level |
| cpha | input | 1 | Clock phase; selects the sampling edge |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | One-cycle pulse on the sampling edge |
| shift_stb | output | 1 | One-cycle pulse on the shifting edge |
| timer_expire | output | 1 | One-cycle pulse when the reload timer wraps |

## Verification
A wrong prescaler or phase count shows up as an edge of `sclk` that comes too early or too late. The checks find it at the first edge after enable, since every cycle is compared against edge times computed from the tick arithmetic. A wrong level register or an inverted phase mapping puts a strobe on the wrong edge or changes `sclk` without a strobe, which is visible on the very next edge. A faulty stop or timer path shows as an extra trailing edge after `en` falls, or as an expiry pulse that is off by a whole period. The sweep covers several prescale, length, polarity and phase combinations, and the timer runs include the 65536-tick reload.

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int EXP_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             timer_mode,
  input  logic [EXP_W-1:0] prescale_exp,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             timer_expire
);
  localparam int DIV_W = 1 << EXP_W;
  localparam int TMR_W = 2 * CNT_W;

  logic [DIV_W-1:0] presc;
  logic [DIV_W-1:0] presc_mask;
  logic             tick;
  logic             act;
  logic [CNT_W-1:0] ph_cnt;
  logic [CNT_W-1:0] ph_len;
  logic             ph_end;
  logic [TMR_W-1:0] tmr_cnt;
  logic [TMR_W-1:0] reload;
  logic             tmr_end;

  assign presc_mask = ~({DIV_W{1'b1}} << prescale_exp);
  assign tick       = (presc == presc_mask);
  assign sclk       = act ^ cpol;
  assign ph_len     = sclk ? hi_len : lo_len;
  assign ph_end     = tick && (ph_len == '0 || ph_cnt == ph_len - CNT_W'(1));
  assign reload     = {hi_len, lo_len};
  assign tmr_end    = tick && (tmr_cnt == reload - TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc        <= '0;
      act          <= 1'b0;
      ph_cnt       <= '0;
      tmr_cnt      <= '0;
      sample_stb   <= 1'b0;
      shift_stb    <= 1'b0;
      timer_expire <= 1'b0;
    end else begin
      sample_stb   <= 1'b0;
      shift_stb    <= 1'b0;
      timer_expire <= 1'b0;
      if (timer_mode) begin
        act    <= 1'b0;
        ph_cnt <= '0;
        if (en) begin
          presc <= tick ? '0 : presc + DIV_W'(1);
          if (tick) tmr_cnt <= tmr_end ? '0 : tmr_cnt + TMR_W'(1);
          timer_expire <= tmr_end;
        end else begin
          presc   <= '0;
          tmr_cnt <= '0;
        end
      end else begin
        tmr_cnt <= '0;
        if (!en && !act) begin
          presc  <= '0;
          ph_cnt <= '0;
        end else begin
          presc <= tick ? '0 : presc + DIV_W'(1);
          if (ph_end) begin
            ph_cnt     <= '0;
            act        <= ~act;
            sample_stb <= act ~^ cpha;
            shift_stb  <= act ^ cpha;
          end else if (tick) begin
            ph_cnt <= ph_cnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic timer_mode,
  input logic cpol,
  input logic sclk,
  input logic sample_stb,
  input logic shift_stb,
  input logic timer_expire
);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  assert_strobe_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> (sclk != $past(sclk)));

  assert_edge_has_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(timer_mode) && $stable(cpol) && sclk != $past(sclk)) |-> (sample_stb || shift_stb));

  assert_sample_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_shift_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> !shift_stb);

  assert_timer_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timer_mode) |-> !(sample_stb || shift_stb));

  assert_expire_in_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expire |-> $past(timer_mode));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .timer_mode(timer_mode), .cpol(cpol),
  .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb),
  .timer_expire(timer_expire)
);

// File: tb/sim_spi_sclk_gen.sv
module sim_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       timer_mode = 1'b0;
  logic [3:0] prescale_exp = '0;
  logic [7:0] hi_len = '0;
  logic [7:0] lo_len = '0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, sample_stb, shift_stb, timer_expire;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_sclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .timer_mode(timer_mode),
    .prescale_exp(prescale_exp), .hi_len(hi_len), .lo_len(lo_len),
    .cpol(cpol), .cpha(cpha), .sclk(sclk), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .timer_expire(timer_expire)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic idle_outputs(input string req, input bit pol);
    chk(sclk == pol, req, int'(sclk), int'(pol));
    chk(!sample_stb && !shift_stb, req, int'({sample_stb, shift_stb}), 0);
    chk(!timer_expire, req, int'(timer_expire), 0);
  endtask

  task automatic run_clk(input int e, input int h, input int l, input bit pol, input bit pha);
    int t, lh, ll, lidle, lact, nxt, edges, c, e4, lmax;
    bit a, es, esh;
    string tag;
    t = 1 << e;
    lh = (h == 0) ? 1 : h;
    ll = (l == 0) ? 1 : l;
    lidle = pol ? lh : ll;
    lact  = pol ? ll : lh;
    lmax  = (lh > ll) ? lh : ll;
    @(negedge clk);
    prescale_exp = 4'(e); hi_len = 8'(h); lo_len = 8'(l);
    cpol = pol; cpha = pha; timer_mode = 1'b0; en = 1'b0;
    @(negedge clk);
    idle_outputs("R5 idle level", pol);
    en = 1'b1;
    c = 0; a = 1'b0; edges = 0; nxt = lidle * t; e4 = 0;
    while (edges < 4 || c < e4 + 2 * lmax * t + 2) begin
      @(negedge clk);
      c++;
      es = 1'b0; esh = 1'b0;
      if (edges < 4 && c == nxt) begin
        es  = a ? pha : !pha;
        esh = !es;
        a = !a;
        edges++;
        nxt = nxt + (a ? lact : lidle) * t;
        if (edges == 4) e4 = c;
      end
      if (edges == 0) tag = "R10 first edge";
      else if (edges < 4) tag = (h == 0 || l == 0) ? "R4 zero length R2" : "R3 phase length R2";
      else tag = "R8 stop after enable drop";
      chk(sclk == (pol ^ a), tag, int'(sclk), int'(pol ^ a));
      chk(sample_stb == es, "R6 sample strobe R7", int'(sample_stb), int'(es));
      chk(shift_stb == esh, "R6 shift strobe R7", int'(shift_stb), int'(esh));
      if (edges == 3 && c + 1 == nxt - lact * t + 1 && en) en = 1'b0;
    end
  endtask

  task automatic run_tmr(input int e, input int h, input int l, input int n, input bit pol);
    int t, r, per, c;
    bit ex;
    t = 1 << e;
    r = (h << 8) | l;
    if (r == 0) r = 65536;
    per = r * t;
    @(negedge clk);
    prescale_exp = 4'(e); hi_len = 8'(h); lo_len = 8'(l);
    cpol = pol; timer_mode = 1'b1; en = 1'b1;
    for (c = 1; c <= n * per + 2; c++) begin
      @(negedge clk);
      ex = (c % per == 0);
      chk(timer_expire == ex, "R9 expiry period R2", int'(timer_expire), int'(ex));
      chk(sclk == pol && !sample_stb && !shift_stb, "R9 clock quiet in timer mode",
          int'({sclk, sample_stb, shift_stb}), int'({pol, 2'b00}));
    end
    en = 1'b0;
    @(negedge clk);
    timer_mode = 1'b0;
    @(negedge clk);
    idle_outputs("R1 idle after timer", pol);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_outputs("R1 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_outputs("R1 after reset", 1'b0);
    cpol = 1'b1;
    #1;
    idle_outputs("R5 idle high R1", 1'b1);
    @(negedge clk);
    cpol = 1'b0;
    for (int e = 0; e < 3; e++)
      for (int hi = 0; hi < 3; hi++)
        for (int li = 0; li < 3; li++)
          for (int m = 0; m < 4; m++)
            run_clk(e, (hi == 0) ? 0 : (hi == 1) ? 1 : 3,
                    (li == 0) ? 0 : (li == 1) ? 2 : 4, m[1], m[0]);
    run_tmr(0, 0, 3, 4, 1'b0);
    run_tmr(2, 0, 5, 3, 1'b1);
    run_tmr(1, 1, 0, 2, 1'b0);
    run_tmr(0, 0, 0, 1, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule